// File: doc/BRIEF.md
# Processor Port Glue for a GCD Demonstrator

This block sits between a small 8-bit soft processor and the surrounding fabric of a greatest-common-divisor demonstrator. When the processor reads, it puts a port address on `port_id`. A purely combinational selector then places the matching fabric value on `in_port` in that same cycle. The values it can select are the two operand switches and a packed byte of button flags.

When the processor writes, one of two paths captures the data into fabric holding registers:

- **Register-value write.** Qualified by `write_strobe` and decoded on the full 8-bit address.
- **Constant write.** Qualified by `k_write_strobe` and decoded only on the low four address bits.

The holding registers carry the working operands A and B, the GCD result, an iteration count and the phase code. The program reports its phase by writing one-hot codes: Init 0x01, Sub 0x02, Mult 0x04, Done 0x08. The glue stores whatever code is written and has no sequencing of its own.

The processor port protocol has no flow control. Reads are answered in the cycle the address appears. Writes are taken on the clock edge that closes the strobe cycle, and no back-pressure is ever applied.

Top module: `gcd_port_glue`

## Requirements
- R1: While `rst_n` is low, all five holding outputs (`a_out`, `b_out`, `gcd_out`, `icount_out`, `state_out`) are 0x00.
- R2: `in_port` is combinational. It shows `ain` when `port_id` is 0x00 and `bin` when `port_id` is 0x01, in the same cycle.
- R3: At `port_id` 0x02, `in_port` returns the button byte. Bit 0 is `btn_start_ack`, bit 1 is `btn_step`, and bits 7..2 read 0.
- R4: Any other read address returns 0x00 on `in_port`. All 8 address bits are decoded, so 0x80 and 0x82 are unmapped.
- R5: With `write_strobe` high, `out_port` is loaded at the next clock edge into a holding register selected by `port_id`. The mapping is 0x10 for A, 0x11 for B, 0x12 for GCD, 0x13 for the count and 0x14 for the state.
- R6: The register-value path compares all 8 address bits. A write to 0x90 or 0x01 changes no holding register.
- R7: With `k_write_strobe` high and `write_strobe` low, the path uses only `port_id[3:0]`; bits 7..4 are ignored. Low nibble 0x1 loads `out_port` into the state register, and low nibble 0x2 loads it into the count register.
- R8: A constant write whose low nibble is neither 0x1 nor 0x2 changes no holding register. This includes a low nibble of 0x0 or 0x4.
- R9: A holding register keeps its value in any cycle with no matching strobed write, whatever `port_id` and `out_port` carry.
- R10: When both strobes are high in one cycle, only the register-value write takes effect and the constant write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_id | input | 8 | Port address from the processor |
| in_port | output | 8 | Read data to the processor |
| write_strobe | input | 1 | Register-value write qualifier |
| k_write_strobe | input | 1 | Constant write qualifier |
| out_port | input | 8 | Write data from the processor |
| ain | input | 8 | Operand A switches |
| bin | input | 8 | Operand B switches |
| btn_start_ack | input | 1 | Start/acknowledge button level |
| btn_step | input | 1 | Step button level |
| a_out | output | 8 | Working operand A |
| b_out | output | 8 | Working operand B |
| gcd_out | output | 8 | GCD result |
| icount_out | output | 8 | Iteration count |
| state_out | output | 8 | Phase code written by the program |

## Verification
A walk of register-value writes gives each holding register a distinct byte, so any mis-steered enable or swapped register shows up as a wrong value in one of the five registers.

Constant writes are then tried three ways:
- with nonzero upper address bits, to confirm those bits are ignored;
- with the low nibbles 0x0 and 0x4, to confirm nothing is loaded;
- with both strobes raised together, which separates the priority rule from a merge of the two paths.

Read tests use asymmetric operand bytes and every combination of the button levels. They also probe addresses that alias the mapped ports in their low bits, which exposes any decode that is only partial.

// File: rtl/gluepkg.sv
package gluepkg;
  localparam int NREG = 5;

  typedef enum logic [2:0] {
    IDX_A     = 3'd0,
    IDX_B     = 3'd1,
    IDX_GCD   = 3'd2,
    IDX_CNT   = 3'd3,
    IDX_STATE = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/glue_read_mux.sv
module glue_read_mux #(
  parameter int          DATA_W  = 8,
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  RD_A    = 8'h00,
  parameter logic [7:0]  RD_B    = 8'h01,
  parameter logic [7:0]  RD_BTN  = 8'h02
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              btn_go,
  input  logic              btn_step,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - 2;

  logic [DATA_W-1:0] btn_byte;
  assign btn_byte = {{PAD_W{1'b0}}, btn_step, btn_go};

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(RD_A))        rdata = opa;
    else if (addr == ADDR_W'(RD_B))   rdata = opb;
    else if (addr == ADDR_W'(RD_BTN)) rdata = btn_byte;
  end
endmodule

// File: rtl/glue_write_decode.sv
module glue_write_decode
  import gluepkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter int         KADDR_W = 4,
  parameter logic [7:0] WR_BASE = 8'h10,
  parameter logic [3:0] K_STATE = 4'h1,
  parameter logic [3:0] K_CNT   = 4'h2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_stb,
  input  logic              k_stb,
  output logic [NREG-1:0]   we
);
  logic [NREG-1:0]    reg_hit;
  logic [NREG-1:0]    k_hit;
  logic [KADDR_W-1:0] k_addr;

  assign k_addr = addr[KADDR_W-1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(int'(WR_BASE) + i);
    assign reg_hit[i] = (addr == SLOT);
  end

  always_comb begin
    k_hit = '0;
    k_hit[int'(IDX_STATE)] = (k_addr == KADDR_W'(K_STATE));
    k_hit[int'(IDX_CNT)]   = (k_addr == KADDR_W'(K_CNT));
  end

  always_comb begin
    if (wr_stb)     we = reg_hit;
    else if (k_stb) we = k_hit;
    else            we = '0;
  end
endmodule

// File: rtl/glue_hold_reg.sv
module glue_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  // R5
  load_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d));
endmodule

// File: rtl/gcd_port_glue.sv
module gcd_port_glue
  import gluepkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter int         ADDR_W  = 8,
  parameter int         KADDR_W = 4,
  parameter logic [7:0] WR_BASE = 8'h10,
  parameter logic [3:0] K_STATE = 4'h1,
  parameter logic [3:0] K_CNT   = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] port_id,
  output logic [DATA_W-1:0] in_port,
  input  logic              write_strobe,
  input  logic              k_write_strobe,
  input  logic [DATA_W-1:0] out_port,
  input  logic [DATA_W-1:0] ain,
  input  logic [DATA_W-1:0] bin,
  input  logic              btn_start_ack,
  input  logic              btn_step,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] b_out,
  output logic [DATA_W-1:0] gcd_out,
  output logic [DATA_W-1:0] icount_out,
  output logic [DATA_W-1:0] state_out
);
  localparam logic [ADDR_W-1:0] A_SLOT     = ADDR_W'(int'(WR_BASE) + int'(IDX_A));
  localparam logic [ADDR_W-1:0] STATE_SLOT = ADDR_W'(int'(WR_BASE) + int'(IDX_STATE));

  logic [NREG-1:0]   we;
  logic [DATA_W-1:0] hold_q [NREG];

  glue_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .addr(port_id), .opa(ain), .opb(bin),
    .btn_go(btn_start_ack), .btn_step(btn_step), .rdata(in_port)
  );

  glue_write_decode #(
    .ADDR_W(ADDR_W), .KADDR_W(KADDR_W), .WR_BASE(WR_BASE),
    .K_STATE(K_STATE), .K_CNT(K_CNT)
  ) u_dec (
    .addr(port_id), .wr_stb(write_strobe), .k_stb(k_write_strobe), .we(we)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    glue_hold_reg #(.W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .we(we[i]), .d(out_port), .q(hold_q[i])
    );
  end

  assign a_out      = hold_q[int'(IDX_A)];
  assign b_out      = hold_q[int'(IDX_B)];
  assign gcd_out    = hold_q[int'(IDX_GCD)];
  assign icount_out = hold_q[int'(IDX_CNT)];
  assign state_out  = hold_q[int'(IDX_STATE)];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (state_out == '0 || rst_n));
  // R2
  read_opa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_id == ADDR_W'(0) |-> in_port == ain);
  // R4
  read_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_id[ADDR_W-1] |-> in_port == '0);
  // R6
  full_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write_strobe && port_id != A_SLOT) |=> $stable(a_out));
  // R7
  k_state_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k_write_strobe && !write_strobe && port_id[KADDR_W-1:0] == KADDR_W'(K_STATE))
      |=> state_out == $past(out_port));
  // R10
  strobe_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write_strobe && k_write_strobe && port_id != STATE_SLOT) |=> $stable(state_out));
endmodule

// File: tb/tb_gcd_port_glue.sv
module tb_gcd_port_glue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port_id = 8'h00;
  logic [7:0] in_port;
  logic       write_strobe = 1'b0;
  logic       k_write_strobe = 1'b0;
  logic [7:0] out_port = 8'h00;
  logic [7:0] ain = 8'h00;
  logic [7:0] bin = 8'h00;
  logic       btn_start_ack = 1'b0;
  logic       btn_step = 1'b0;
  logic [7:0] a_out, b_out, gcd_out, icount_out, state_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gcd_port_glue dut (
    .clk(clk), .rst_n(rst_n), .port_id(port_id), .in_port(in_port),
    .write_strobe(write_strobe), .k_write_strobe(k_write_strobe),
    .out_port(out_port), .ain(ain), .bin(bin),
    .btn_start_ack(btn_start_ack), .btn_step(btn_step),
    .a_out(a_out), .b_out(b_out), .gcd_out(gcd_out),
    .icount_out(icount_out), .state_out(state_out)
  );

  // {req, ws, ks, port_id, data, expA, expB, expGCD, expCNT, expSTATE}
  localparam int NV = 15;
  localparam logic [61:0] VEC [NV] = '{
    {4'd5,  1'b1, 1'b0, 8'h10, 8'hAA, 8'hAA, 8'h00, 8'h00, 8'h00, 8'h00}, // R5
    {4'd5,  1'b1, 1'b0, 8'h11, 8'hBB, 8'hAA, 8'hBB, 8'h00, 8'h00, 8'h00}, // R5
    {4'd5,  1'b1, 1'b0, 8'h12, 8'h0C, 8'hAA, 8'hBB, 8'h0C, 8'h00, 8'h00}, // R5
    {4'd5,  1'b1, 1'b0, 8'h13, 8'h05, 8'hAA, 8'hBB, 8'h0C, 8'h05, 8'h00}, // R5
    {4'd5,  1'b1, 1'b0, 8'h14, 8'h02, 8'hAA, 8'hBB, 8'h0C, 8'h05, 8'h02}, // R5
    {4'd7,  1'b0, 1'b1, 8'h01, 8'h01, 8'hAA, 8'hBB, 8'h0C, 8'h05, 8'h01}, // R7
    {4'd7,  1'b0, 1'b1, 8'hF1, 8'h08, 8'hAA, 8'hBB, 8'h0C, 8'h05, 8'h08}, // R7
    {4'd7,  1'b0, 1'b1, 8'h32, 8'h07, 8'hAA, 8'hBB, 8'h0C, 8'h07, 8'h08}, // R7
    {4'd8,  1'b0, 1'b1, 8'h10, 8'h55, 8'hAA, 8'hBB, 8'h0C, 8'h07, 8'h08}, // R8
    {4'd8,  1'b0, 1'b1, 8'h04, 8'h66, 8'hAA, 8'hBB, 8'h0C, 8'h07, 8'h08}, // R8
    {4'd6,  1'b1, 1'b0, 8'h90, 8'h77, 8'hAA, 8'hBB, 8'h0C, 8'h07, 8'h08}, // R6
    {4'd6,  1'b1, 1'b0, 8'h01, 8'h77, 8'hAA, 8'hBB, 8'h0C, 8'h07, 8'h08}, // R6
    {4'd9,  1'b0, 1'b0, 8'h10, 8'h99, 8'hAA, 8'hBB, 8'h0C, 8'h07, 8'h08}, // R9
    {4'd10, 1'b1, 1'b1, 8'h11, 8'h44, 8'hAA, 8'h44, 8'h0C, 8'h07, 8'h08}, // R10
    {4'd10, 1'b1, 1'b1, 8'h14, 8'h04, 8'hAA, 8'h44, 8'h0C, 8'h07, 8'h04}  // R10
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [39:0] e);
    check(req, "a_out",      a_out,      e[39:32]);
    check(req, "b_out",      b_out,      e[31:24]);
    check(req, "gcd_out",    gcd_out,    e[23:16]);
    check(req, "icount_out", icount_out, e[15:8]);
    check(req, "state_out",  state_out,  e[7:0]);
  endtask

  task automatic read_at(input logic [7:0] a, input string req, input logic [7:0] exp);
    port_id = a;
    #1;
    check(req, "in_port", in_port, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1", 40'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      write_strobe   = VEC[v][57];
      k_write_strobe = VEC[v][56];
      port_id        = VEC[v][55:48];
      out_port       = VEC[v][47:40];
      @(posedge clk);
      #1;
      write_strobe   = 1'b0;
      k_write_strobe = 1'b0;
      check_all($sformatf("R%0d", int'(VEC[v][61:58])), VEC[v][39:0]);
    end

    // R9: idle cycles with moving address and data
    @(negedge clk);
    port_id = 8'h12; out_port = 8'hFF;
    @(posedge clk); #1;
    port_id = 8'h14; out_port = 8'h3E;
    @(posedge clk); #1;
    check_all("R9", {8'hAA, 8'h44, 8'h0C, 8'h07, 8'h04});

    // R2, R3, R4: combinational reads
    @(negedge clk);
    ain = 8'h3C; bin = 8'hA5;
    read_at(8'h00, "R2", 8'h3C);
    read_at(8'h01, "R2", 8'hA5);
    ain = 8'hC3;
    read_at(8'h00, "R2", 8'hC3);
    btn_start_ack = 1'b0; btn_step = 1'b0;
    read_at(8'h02, "R3", 8'h00);
    btn_start_ack = 1'b1; btn_step = 1'b0;
    read_at(8'h02, "R3", 8'h01);
    btn_start_ack = 1'b0; btn_step = 1'b1;
    read_at(8'h02, "R3", 8'h02);
    btn_start_ack = 1'b1; btn_step = 1'b1;
    read_at(8'h02, "R3", 8'h03);
    read_at(8'h80, "R4", 8'h00);
    read_at(8'h82, "R4", 8'h00);
    read_at(8'h03, "R4", 8'h00);
    read_at(8'h10, "R4", 8'h00);

    // R1: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_all("R1", 40'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule